// File: doc/BRIEF.md
# Terminal Reset and Startup Sequencer

This block brings a bus remote terminal up after a hardware master reset. While the active-low master reset input is low, every register in the block is cleared and its outputs are held low. When the input returns high, the block counts out a fixed settling time and then latches the configuration strap pins into a status word. Next it can run a pattern self-test over the upper region of the attached single-port RAM, controlled by a strap. Whether or not the test runs, the block then zeroes that upper region.

When the sequence ends, the block takes one of two paths. It either raises READY and gives the RAM to the host, or it keeps READY low and sends a one-cycle start pulse to the EEPROM auto-initialization engine. Until READY is high, every host read returns the status word. After READY, host reads and writes go to the RAM. A write to the configuration word can start execution or perform a software reset. The software reset stops execution and leaves the status word and the RAM contents as they are.

Top module: `term_startup_seq`

## Requirements
- R1: While `mreset_n` is low, `ready_o`, `stex_o`, `bist_fail_o`, `ee_start_o` and `ram_en_o` are 0, and `host_rdata_o` reads 0.
- R2: The straps are latched on the DLY_CYC-th rising clock edge after `mreset_n` rises. DLY_CYC is DELAY_NS/CLK_PERIOD_NS rounded up, which is 50 with the defaults. The status word holds terminal address in bits 4:0, parity in bit 5, auto-init enable in bit 6, lock in bit 7 and interrupt select in bit 8. Its upper bits are 0.
- R3: While `ready_o` is 0, `host_rdata_o` shows the status word for any host address.
- R4: With the test-disable strap at 0, every word above address 0x1F is written with 0xAAAA and read back, then written with 0x5555 and read back. The test covers all of these words even after a mismatch. Any mismatch sets `bist_fail_o`, and the word at address 0x14 is written with 0x0001, whose bit 0 is the memory-test-fail flag.
- R5: With the test-disable strap at 1, no pattern is written, `bist_fail_o` stays 0 and address 0x14 is not written.
- R6: When the sequence ends, every RAM word above 0x1F holds 0x0000. Words 0x00 to 0x1F are unchanged, except for 0x14 under R4.
- R7: If the latched auto-init bit is 0, `ready_o` rises and then stays high until the next master reset. `ee_start_o` is never pulsed.
- R8: If the latched auto-init bit is 1, `ee_start_o` is high for exactly one cycle and `ready_o` stays 0.
- R9: Once `ready_o` is 1, a host write stores `host_wdata_i` at `host_addr_i`. A host read returns that RAM word on `host_rdata_o` one cycle after the request.
- R10: A host write to address 0x00 with bit 0 set makes `stex_o` 1 from the next cycle. The write has this effect only while `ready_o` is 1. Host writes made before READY are ignored and do not reach the RAM.
- R11: A host write to address 0x00 with bit 1 set is a software reset. It clears `stex_o`, and bit 1 takes priority over bit 0. `ready_o` and the RAM contents, apart from the written word, are left unchanged.
- R12: Pulling `mreset_n` low in the middle of the sequence aborts it at once. The next release runs the whole sequence again from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mreset_n | input | 1 | Master reset, active low, asynchronous. The sequence starts on its rising edge |
| strap_rta | input | 5 | Terminal address strap |
| strap_rtap | input | 1 | Address parity strap |
| strap_auto | input | 1 | Auto-initialization enable strap |
| strap_lock | input | 1 | Lock strap |
| strap_isel | input | 1 | Interrupt select strap |
| strap_mtoff | input | 1 | Memory test disable strap |
| host_rd_i | input | 1 | Host read request |
| host_wr_i | input | 1 | Host write request |
| host_addr_i | input | AW | Host address |
| host_wdata_i | input | DW | Host write data |
| host_rdata_o | output | DW | Host read data |
| ram_en_o | output | 1 | RAM access enable |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | AW | RAM address |
| ram_wdata_o | output | DW | RAM write data |
| ram_rdata_i | input | DW | RAM read data, one cycle after the read |
| ready_o | output | 1 | Host may initialize the terminal |
| stex_o | output | 1 | Execution started |
| bist_fail_o | output | 1 | Memory self-test failed |
| ee_start_o | output | 1 | One-cycle start pulse for EEPROM auto-initialization |

## Verification
The bench runs the sequence under all four combinations of the test-disable and auto-init straps. It adds a stuck-at-0 data bit in one RAM word, so that a failing test can be told apart from a passing one and from a skipped one. The strap pins carry a different value just before, at, and just after the capture edge, which separates an early or late capture from a correct one. Each run ends with a sweep over every RAM address. The sweep shows that the low region is preserved and that the flag word is written only on failure. One run is aborted mid-test by a master reset, and the host-side writes exercise the start, software-reset and pre-READY-ignored cases.

// File: rtl/tss_pkg.sv
package tss_pkg;
    typedef enum logic [1:0] {T_DELAY, T_WALK, T_READY, T_AUTO} top_ph_t;
    typedef enum logic [2:0] {W_IDLE, W_TEST, W_BITW, W_CLEAR, W_DONE} walk_ph_t;
endpackage

// File: rtl/tss_delay_timer.sv
module tss_delay_timer #(
    parameter int DLY_CYC = 50
) (
    input  logic clk,
    input  logic mreset_n,
    output logic fire_o
);
    localparam int CW = $clog2(DLY_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(DLY_CYC - 1);

    typedef struct packed {
        logic          armed;
        logic [CW-1:0] cnt;
    } dst_t;

    dst_t q, n;

    always_comb begin
        n      = q;
        fire_o = q.armed && (q.cnt == LAST);
        if (q.armed) begin
            if (fire_o) n.armed = 1'b0;
            else        n.cnt   = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge mreset_n) begin
        if (!mreset_n) q <= '{armed: 1'b1, cnt: '0};
        else           q <= n;
    end

    // R2: the capture strobe happens once per reset release
    a_r2_single_fire: assert property (@(posedge clk) disable iff (!mreset_n)
        fire_o |=> !fire_o);
endmodule

// File: rtl/tss_ram_walker.sv
module tss_ram_walker
    import tss_pkg::*;
#(
    parameter int AW       = 8,
    parameter int DW       = 16,
    parameter int LOW_TOP  = 31,
    parameter int BIT_ADDR = 20,
    parameter int FAIL_BIT = 0
) (
    input  logic          clk,
    input  logic          mreset_n,
    input  logic          start_i,
    input  logic          run_test_i,
    output logic          ram_en_o,
    output logic          ram_we_o,
    output logic [AW-1:0] ram_addr_o,
    output logic [DW-1:0] ram_wdata_o,
    input  logic [DW-1:0] ram_rdata_i,
    output logic          done_o,
    output logic          fail_o
);
    localparam logic [AW-1:0] LOW_A  = AW'(LOW_TOP);
    localparam logic [AW-1:0] FIRST  = AW'(LOW_TOP + 1);
    localparam logic [AW-1:0] LAST   = {AW{1'b1}};
    localparam logic [AW-1:0] BIT_A  = AW'(BIT_ADDR);
    localparam logic [DW-1:0] PAT_A  = {(DW/2){2'b10}};
    localparam logic [DW-1:0] PAT_B  = ~PAT_A;
    localparam logic [DW-1:0] FLAG_W = DW'(1) << FAIL_BIT;

    typedef struct packed {
        walk_ph_t      ph;
        logic [AW-1:0] addr;
        logic [2:0]    step;
        logic          fail;
    } wst_t;

    wst_t q, n;

    always_comb begin
        n           = q;
        ram_en_o    = 1'b0;
        ram_we_o    = 1'b0;
        ram_addr_o  = q.addr;
        ram_wdata_o = '0;
        case (q.ph)
            W_IDLE: if (start_i) begin
                n.addr = FIRST;
                n.step = '0;
                n.ph   = run_test_i ? W_TEST : W_CLEAR;
            end
            W_TEST: begin
                n.step = q.step + 3'd1;
                case (q.step)
                    3'd0: begin
                        ram_en_o = 1'b1; ram_we_o = 1'b1; ram_wdata_o = PAT_A;
                    end
                    3'd1: ram_en_o = 1'b1;
                    3'd2: begin
                        if (ram_rdata_i != PAT_A) n.fail = 1'b1;
                        ram_en_o = 1'b1; ram_we_o = 1'b1; ram_wdata_o = PAT_B;
                    end
                    3'd3: ram_en_o = 1'b1;
                    default: begin
                        if (ram_rdata_i != PAT_B) n.fail = 1'b1;
                        n.step = '0;
                        if (q.addr == LAST) begin
                            n.addr = FIRST;
                            n.ph   = n.fail ? W_BITW : W_CLEAR;
                        end else begin
                            n.addr = q.addr + 1'b1;
                        end
                    end
                endcase
            end
            W_BITW: begin
                ram_en_o = 1'b1; ram_we_o = 1'b1;
                ram_addr_o = BIT_A; ram_wdata_o = FLAG_W;
                n.ph = W_CLEAR;
            end
            W_CLEAR: begin
                ram_en_o = 1'b1; ram_we_o = 1'b1;
                if (q.addr == LAST) n.ph = W_DONE;
                else                n.addr = q.addr + 1'b1;
            end
            default: ;
        endcase
    end

    assign done_o = (q.ph == W_DONE);
    assign fail_o = q.fail;

    always_ff @(posedge clk or negedge mreset_n) begin
        if (!mreset_n) q <= '{ph: W_IDLE, addr: '0, step: '0, fail: 1'b0};
        else           q <= n;
    end

    // R4: once set, the fail flag stays set
    a_r4_fail_sticky: assert property (@(posedge clk) disable iff (!mreset_n)
        fail_o |=> fail_o);
    // R6: the low region is written only at the flag word
    a_r6_low_region_kept: assert property (@(posedge clk) disable iff (!mreset_n)
        ram_we_o |-> (ram_addr_o > LOW_A || ram_addr_o == BIT_A));
endmodule

// File: rtl/term_startup_seq.sv
module term_startup_seq
    import tss_pkg::*;
#(
    parameter int AW            = 8,
    parameter int DW            = 16,
    parameter int CLK_PERIOD_NS = 4,
    parameter int DELAY_NS      = 200,
    parameter int LOW_TOP       = 31,
    parameter int BIT_ADDR      = 20,
    parameter int FAIL_BIT      = 0,
    parameter int CFG1_ADDR     = 0,
    parameter int STEX_BIT      = 0,
    parameter int SRST_BIT      = 1
) (
    input  logic          clk,
    input  logic          mreset_n,
    input  logic [4:0]    strap_rta,
    input  logic          strap_rtap,
    input  logic          strap_auto,
    input  logic          strap_lock,
    input  logic          strap_isel,
    input  logic          strap_mtoff,
    input  logic          host_rd_i,
    input  logic          host_wr_i,
    input  logic [AW-1:0] host_addr_i,
    input  logic [DW-1:0] host_wdata_i,
    output logic [DW-1:0] host_rdata_o,
    output logic          ram_en_o,
    output logic          ram_we_o,
    output logic [AW-1:0] ram_addr_o,
    output logic [DW-1:0] ram_wdata_o,
    input  logic [DW-1:0] ram_rdata_i,
    output logic          ready_o,
    output logic          stex_o,
    output logic          bist_fail_o,
    output logic          ee_start_o
);
    localparam int DLY_CYC = (DELAY_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    localparam int AUTO_POS = 6;
    localparam logic [AW-1:0] CFG1_A = AW'(CFG1_ADDR);

    typedef struct packed {
        top_ph_t       ph;
        logic [DW-1:0] status;
        logic          stex;
        logic          ee_start;
        logic          rd_ram;
    } tst_t;

    tst_t q, n;

    logic          fire;
    logic          walk_done;
    logic          w_en, w_we;
    logic [AW-1:0] w_addr;
    logic [DW-1:0] w_wdata;

    tss_delay_timer #(.DLY_CYC(DLY_CYC)) u_dly (
        .clk(clk), .mreset_n(mreset_n), .fire_o(fire)
    );

    tss_ram_walker #(
        .AW(AW), .DW(DW), .LOW_TOP(LOW_TOP), .BIT_ADDR(BIT_ADDR), .FAIL_BIT(FAIL_BIT)
    ) u_walk (
        .clk(clk), .mreset_n(mreset_n),
        .start_i(fire), .run_test_i(!strap_mtoff),
        .ram_en_o(w_en), .ram_we_o(w_we), .ram_addr_o(w_addr),
        .ram_wdata_o(w_wdata), .ram_rdata_i(ram_rdata_i),
        .done_o(walk_done), .fail_o(bist_fail_o)
    );

    always_comb begin
        n          = q;
        n.ee_start = 1'b0;
        n.rd_ram   = 1'b0;
        case (q.ph)
            T_DELAY: if (fire) begin
                n.status = DW'({strap_isel, strap_lock, strap_auto, strap_rtap, strap_rta});
                n.ph     = T_WALK;
            end
            T_WALK: if (walk_done) begin
                if (q.status[AUTO_POS]) begin
                    n.ph       = T_AUTO;
                    n.ee_start = 1'b1;
                end else begin
                    n.ph = T_READY;
                end
            end
            T_READY: begin
                n.rd_ram = host_rd_i && !host_wr_i;
                if (host_wr_i && host_addr_i == CFG1_A) begin
                    if (host_wdata_i[SRST_BIT])      n.stex = 1'b0;
                    else if (host_wdata_i[STEX_BIT]) n.stex = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_comb begin
        if (q.ph == T_READY) begin
            ram_en_o    = host_rd_i || host_wr_i;
            ram_we_o    = host_wr_i;
            ram_addr_o  = host_addr_i;
            ram_wdata_o = host_wdata_i;
        end else begin
            ram_en_o    = w_en;
            ram_we_o    = w_we;
            ram_addr_o  = w_addr;
            ram_wdata_o = w_wdata;
        end
    end

    assign host_rdata_o = q.rd_ram ? ram_rdata_i : q.status;
    assign ready_o      = (q.ph == T_READY);
    assign stex_o       = q.stex;
    assign ee_start_o   = q.ee_start;

    always_ff @(posedge clk or negedge mreset_n) begin
        if (!mreset_n) q <= '{ph: T_DELAY, status: '0, stex: 1'b0, ee_start: 1'b0, rd_ram: 1'b0};
        else           q <= n;
    end

    // R8: the auto-init start is a single-cycle pulse
    a_r8_start_pulse: assert property (@(posedge clk) disable iff (!mreset_n)
        ee_start_o |=> !ee_start_o);
    // R8: READY never follows an auto-init start
    a_r8_no_ready_after_start: assert property (@(posedge clk) disable iff (!mreset_n)
        ee_start_o |=> !ready_o);
    // R7: READY holds until the next master reset
    a_r7_ready_sticky: assert property (@(posedge clk) disable iff (!mreset_n)
        ready_o |=> ready_o);
    // R10: execution can only be running with READY high
    a_r10_stex_needs_ready: assert property (@(posedge clk) disable iff (!mreset_n)
        stex_o |-> ready_o);
endmodule

// File: tb/term_startup_seq_tb.sv
module term_startup_seq_tb;
    logic        clk = 1'b0;
    logic        mreset_n = 1'b0;
    logic [4:0]  strap_rta = '0;
    logic        strap_rtap = 1'b0, strap_auto = 1'b0, strap_lock = 1'b0;
    logic        strap_isel = 1'b0, strap_mtoff = 1'b0;
    logic        host_rd = 1'b0, host_wr = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        ram_en, ram_we;
    logic [7:0]  ram_addr;
    logic [15:0] ram_wdata;
    logic [15:0] ram_rdata = '0;
    logic        ready, stex, bist_fail, ee_start;

    int n_vec = 0;
    int n_bad = 0;
    int aa_writes = 0;
    int ee_cnt = 0;
    logic        fault_en = 1'b0;
    logic [7:0]  fault_addr = 8'h80;
    logic [15:0] mem [256];

    always #2 clk = ~clk;

    term_startup_seq u_dut (
        .clk(clk), .mreset_n(mreset_n),
        .strap_rta(strap_rta), .strap_rtap(strap_rtap), .strap_auto(strap_auto),
        .strap_lock(strap_lock), .strap_isel(strap_isel), .strap_mtoff(strap_mtoff),
        .host_rd_i(host_rd), .host_wr_i(host_wr), .host_addr_i(host_addr),
        .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
        .ram_en_o(ram_en), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
        .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata),
        .ready_o(ready), .stex_o(stex), .bist_fail_o(bist_fail), .ee_start_o(ee_start)
    );

    always @(posedge clk) begin
        if (ee_start) ee_cnt <= ee_cnt + 1;
        if (ram_en) begin
            if (ram_we) begin
                mem[ram_addr] <= ram_wdata;
                if (ram_wdata == 16'hAAAA) aa_writes <= aa_writes + 1;
            end else begin
                ram_rdata <= (fault_en && ram_addr == fault_addr) ?
                             (mem[ram_addr] & ~16'h0002) : mem[ram_addr];
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_straps(input logic [8:0] v);
        {strap_isel, strap_lock, strap_auto, strap_rtap, strap_rta} = v;
    endtask

    task automatic host_read(input logic [7:0] a, output logic [15:0] d);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        d = host_rdata; host_rd = 1'b0;
    endtask

    task automatic host_write(input logic [7:0] a, input logic [15:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic apply_reset(input logic mt, input logic fe, input logic [8:0] sv);
        @(negedge clk);
        mreset_n = 1'b0;
        host_rd = 1'b0; host_wr = 1'b0;
        strap_mtoff = mt; fault_en = fe;
        set_straps(sv);
        for (int a = 0; a < 256; a++) mem[a] = (a > 31) ? 16'hFFFF : (16'h1000 | 16'(a));
        aa_writes = 0; ee_cnt = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ready", 32'(ready), 0);
        chk("R1 stex", 32'(stex), 0);
        chk("R1 bist_fail", 32'(bist_fail), 0);
        chk("R1 ee_start", 32'(ee_start), 0);
        chk("R1 ram_en", 32'(ram_en), 0);
        chk("R1 host_rdata", 32'(host_rdata), 0);
    endtask

    task automatic do_run(input logic [8:0] sv, input logic mt, input logic fe);
        logic [15:0] d;
        logic        au;
        logic        exp_fail;
        int          waited;
        logic [15:0] ev;
        au = sv[6];
        exp_fail = fe && !mt;
        apply_reset(mt, fe, ~sv);
        mreset_n = 1'b1;
        repeat (49) @(posedge clk);
        @(negedge clk);
        set_straps(sv);
        @(posedge clk);
        @(negedge clk);
        set_straps(~sv);
        // R10: a start request before READY is ignored
        host_write(8'h00, 16'h0001);
        // R2, R3: status captured at the 50th edge and shown on any read before READY
        host_read(8'h47, d);
        chk("R2 R3 status", 32'(d), 32'(sv));
        waited = 0;
        while (!ready && !ee_start && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        if (au) begin
            chk("R8 ee_start", 32'(ee_start), 1);
            chk("R8 ready", 32'(ready), 0);
            @(negedge clk);
            chk("R8 ee_start single", 32'(ee_start), 0);
            repeat (20) @(negedge clk);
            chk("R8 ready stays low", 32'(ready), 0);
            chk("R8 pulse count", 32'(ee_cnt), 1);
            chk("R3 status after auto", 32'(host_rdata), 32'(sv));
        end else begin
            chk("R7 ready", 32'(ready), 1);
            repeat (3) @(negedge clk);
            chk("R7 ready held", 32'(ready), 1);
            chk("R7 no ee_start", 32'(ee_cnt), 0);
        end
        chk("R4 R5 bist_fail", 32'(bist_fail), 32'(exp_fail));
        chk("R4 R5 pattern writes", 32'(aa_writes), mt ? 0 : 224);
        for (int a = 0; a < 256; a++) begin
            if (a > 31)                  ev = 16'h0000;
            else if (a == 20 && exp_fail) ev = 16'h0001;
            else                         ev = 16'h1000 | 16'(a);
            chk("R6 R4 R10 ram word", 32'(mem[a]), 32'(ev));
        end
        if (!au) begin
            chk("R10 stex before", 32'(stex), 0);
            host_read(8'h14, d);
            chk("R9 read flag word", 32'(d), exp_fail ? 32'h1 : 32'h1014);
            host_write(8'h40, 16'h1234);
            host_read(8'h40, d);
            chk("R9 write then read", 32'(d), 32'h1234);
            host_write(8'h00, 16'h0001);
            chk("R10 stex set", 32'(stex), 1);
            host_write(8'h00, 16'h0003);
            chk("R11 srst priority", 32'(stex), 0);
            host_write(8'h00, 16'h0001);
            host_write(8'h00, 16'h0002);
            chk("R11 stex cleared", 32'(stex), 0);
            chk("R11 ready kept", 32'(ready), 1);
            host_read(8'h40, d);
            chk("R11 ram kept", 32'(d), 32'h1234);
            host_read(8'h05, d);
            chk("R11 low word kept", 32'(d), 32'h1005);
        end
    endtask

    task automatic do_abort();
        apply_reset(1'b0, 1'b0, 9'h0AB);
        mreset_n = 1'b1;
        repeat (300) @(negedge clk);
        mreset_n = 1'b0;
        #1;
        // R12: abort is immediate
        chk("R12 ram_en", 32'(ram_en), 0);
        chk("R12 ready", 32'(ready), 0);
        chk("R12 status cleared", 32'(host_rdata), 0);
        chk("R12 bist_fail", 32'(bist_fail), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        do_run(9'h135, 1'b0, 1'b0);
        do_run(9'h08A, 1'b0, 1'b1);
        do_run(9'h1BF, 1'b1, 1'b0);
        do_abort();
        do_run(9'h063, 1'b0, 1'b1);
        do_run(9'h0FC, 1'b1, 1'b1);
        do_run(9'h100, 1'b0, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule